// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out store between two unrelated clock domains. A producer pushes words on the write clock and a consumer pulls them on the read clock. Two active-low level flags tell each side how close the store is to running dry or filling up. Both thresholds are set by parameters. The low-level threshold is `AE_OFS` words and the high-level margin is `AF_OFS` words below the usable depth.

Two behaviours are chosen by inputs that are captured while reset is held low. The first is the flag timing. In synchronous timing each flag is a register in its own side's clock domain. In asynchronous timing a flag is pushed one way by an edge of one clock and pulled back by an edge of the other clock, so it moves right after the edge that causes the change. The second is the read style. In normal read style a word is presented one read-clock edge after it is requested. In look-ahead style the oldest word already sits on the output before any request. That output register counts as one extra word of storage, and both flag thresholds move by one word to match.

Top module: `dcfifo_pflag`

## Requirements
- R1: While `rst_n` is low at edges of both clocks, the FIFO empties. After release `ae_n` is 0 and `af_n` is 1.
- R2: Words are read in the order they were written. In normal read style, `rd_data` takes the next word at the `rd_clk` edge where `rd_en_n` is low.
- R3: In normal read style the FIFO holds 2^AW words. A write attempted while it is full is dropped and changes nothing that is read later.
- R4: A read attempted while the FIFO holds nothing is dropped, and `rd_data` keeps its last value.
- R5: In look-ahead style the oldest word shows on `rd_data` with no read request, and the FIFO holds 2^AW+1 words. A request (`rd_en_n` low) consumes the word on show.
- R6: In normal read style `ae_n` is 0 while AE_OFS or fewer words are stored, and 1 while more are stored.
- R7: In look-ahead style `ae_n` is 0 while AE_OFS+1 or fewer words are stored, and 1 while more are stored.
- R8: `af_n` is 0 while D-AF_OFS or more words are stored and 1 while fewer are stored. D is 2^AW in normal style and 2^AW+1 in look-ahead style.
- R9: With asynchronous timing (`sync_sel` = 0 at reset), `af_n` falls right after the `wr_clk` edge of the write that reaches the high threshold. It rises right after the `rd_clk` edge of the read that drops below it.
- R10: With synchronous timing (`sync_sel` = 1 at reset), `af_n` is a `wr_clk` register. It is still 1 half a cycle after the write that reaches the threshold, and it is 0 one `wr_clk` cycle later.
- R11: With asynchronous timing, `ae_n` rises right after the `wr_clk` edge of the write that lifts the count above the low threshold. It falls right after the `rd_clk` edge of the read that brings the count back to the threshold.
- R12: `sync_sel` and `fwft_sel` act only while `rst_n` is low. Changing either input after release has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_en_n | input | 1 | Active-low write request |
| wr_data | input | DW | Word to store |
| rd_clk | input | 1 | Read-side clock |
| rd_en_n | input | 1 | Active-low read request |
| rd_data | output | DW | Word read out (registered) |
| rst_n | input | 1 | Active-low reset, synchronous in each domain |
| sync_sel | input | 1 | Flag timing captured at reset: 1 synchronous, 0 asynchronous |
| fwft_sel | input | 1 | Read style captured at reset: 1 look-ahead, 0 normal |
| ae_n | output | 1 | Active-low almost-empty flag |
| af_n | output | 1 | Active-low almost-full flag |

## Verification
The assertions assume that `rst_n` stays low across at least two rising edges of each clock. This lets every pointer, synchronizer and captured mode bit start from a known value. They also assume that the inputs change away from the clock edges. Exact flag levels are only defined once each side's copy of the other side's pointer has caught up. For that reason the stimulus drives inputs on falling edges and waits several cycles of both clocks after each write or read before it compares a flag level against its threshold. The only exceptions are the checks that measure how quickly a flag moves after a single edge.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the dual-clock FIFO with level flags.
package dcf_pkg;
    // How the level flags are timed; captured while reset is low.
    typedef enum logic {
        TIM_ASYNC = 1'b0,
        TIM_SYNC  = 1'b1
    } flag_timing_e;
endpackage

// File: rtl/dcf_xing.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a Gray-coded value, with conversion to binary.
// Assumes the source is a register whose value changes by at most one bit
// per source-clock edge. A 1-bit toggle passes through unchanged.
module dcf_xing #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Two flops in series to settle the foreign-domain value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_in;
            stage2 <= stage1;
        end
    end

    // Gray to binary: each bit is the XOR of all Gray bits at or above it.
    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            acc        = acc ^ stage2[i];
            bin_out[i] = acc;
        end
    end
endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/1ps
// Write-clock half of the FIFO: write pointer, full detection, the
// registered high-level flag, and the write-side toggles of both
// asynchronous flags. All counts here are of RAM words only. In look-ahead
// style the one extra word in the output register lines up with the
// read-side thresholds.
// Assumes rbin_sync and the toggle inputs are already synchronized to wr_clk.
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int AW     = 4,
    parameter int AE_OFS = 3,
    parameter int AF_OFS = 2,
    parameter int PW     = AW + 1
) (
    input  logic          wr_clk,
    input  logic          rst_n,
    input  logic          wr_en_n,
    input  logic          sync_sel,
    input  logic [PW-1:0] rbin_sync,
    input  logic          af_clr_sync,
    input  logic          ae_set_sync,
    output logic          wr_fire,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic          af_set,
    output logic          ae_clr,
    output logic          af_q,
    output logic          sync_w
);
    localparam int            DEPTH  = 1 << AW;
    localparam logic [PW-1:0] DEPTHV = PW'(DEPTH);
    localparam logic [PW-1:0] AF_LIM = PW'(DEPTH - AF_OFS);
    localparam logic [PW-1:0] AE_LIM = PW'(AE_OFS);

    flag_timing_e  tim_w;
    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_nx;
    logic [PW-1:0] wcount;
    logic [PW-1:0] cnt_after;
    logic          full;

    // Occupancy as seen from the write side and the accept decision.
    always_comb begin
        wcount    = wbin - rbin_sync;
        full      = (wcount == DEPTHV);
        wr_fire   = !wr_en_n && !full;
        cnt_after = wcount + PW'(1);
        wbin_nx   = wbin + PW'(1);
    end

    assign waddr  = wbin[AW-1:0];
    assign sync_w = (tim_w == TIM_SYNC);

    // Pointer advance and mode capture; the timing mode is loaded only in reset.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
            tim_w <= flag_timing_e'(sync_sel);
        end else if (wr_fire) begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    // Registered high-level flag for synchronous timing.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) af_q <= 1'b1;
        else        af_q <= !(wcount >= AF_LIM);
    end

    // Write-edge moves of the asynchronous flags: raise "almost full", drop "almost empty".
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            af_set <= 1'b0;
            ae_clr <= 1'b0;
        end else begin
            if (wr_fire && (cnt_after >= AF_LIM) && (af_set == af_clr_sync))
                af_set <= ~af_set;
            if (wr_fire && (cnt_after > AE_LIM) && (ae_clr == ae_set_sync))
                ae_clr <= ~ae_clr;
        end
    end

    // R3: a write request while full must not move the pointer.
    a_r3_no_write_when_full: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (full && !wr_en_n) |=> (wbin == $past(wbin)));

    // R2: the Gray pointer moves at most one bit per edge.
    a_r2_wgray_one_step: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(wgray ^ $past(wgray)) <= 1));

    // R3: write-side occupancy never exceeds the RAM depth.
    a_r3_count_bound: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wcount <= DEPTHV);

    // R12: captured timing mode is stable outside reset.
    a_r12_mode_held_w: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(sync_w));
endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/1ps
// Read-clock half of the FIFO: read pointer, empty detection, the output
// register (a normal read target or a look-ahead stage), the registered
// low-level flag, and the read-side toggles of both asynchronous flags.
// In look-ahead style the output register word counts toward occupancy.
// Assumes wbin_sync and the toggle inputs are already synchronized to rd_clk.
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int DW     = 8,
    parameter int AW     = 4,
    parameter int AE_OFS = 3,
    parameter int AF_OFS = 2,
    parameter int PW     = AW + 1
) (
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          rd_en_n,
    input  logic          sync_sel,
    input  logic          fwft_sel,
    input  logic [PW-1:0] wbin_sync,
    input  logic [DW-1:0] rd_word,
    input  logic          af_set_sync,
    input  logic          ae_clr_sync,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output logic [DW-1:0] rd_data,
    output logic          ae_set,
    output logic          af_clr,
    output logic          ae_q,
    output logic          sync_r
);
    localparam int DEPTH = 1 << AW;

    flag_timing_e  tim_r;
    logic          fwft_r;
    logic          valid;
    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_nx;
    logic [PW-1:0] rcnt;
    logic [PW-1:0] total;
    logic [PW-1:0] tot_after;
    logic [PW-1:0] ae_lim;
    logic [PW-1:0] af_lim;
    logic          ram_empty;
    logic          pop;
    logic          fetch;

    // Occupancy, thresholds and the pop/fetch decisions for the chosen read style.
    always_comb begin
        rcnt      = wbin_sync - rbin;
        ram_empty = (rcnt == '0);
        total     = rcnt + PW'(fwft_r & valid);
        tot_after = total - PW'(1);
        ae_lim    = PW'(AE_OFS) + PW'(fwft_r);
        af_lim    = PW'(DEPTH - AF_OFS) + PW'(fwft_r);
        if (fwft_r) begin
            pop   = !rd_en_n && valid;
            fetch = !ram_empty && (!valid || pop);
        end else begin
            pop   = !rd_en_n && !ram_empty;
            fetch = pop;
        end
        rbin_nx = rbin + PW'(1);
    end

    assign raddr  = rbin[AW-1:0];
    assign sync_r = (tim_r == TIM_SYNC);

    // Read pointer advance and capture of both mode inputs during reset.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            rbin   <= '0;
            rgray  <= '0;
            tim_r  <= flag_timing_e'(sync_sel);
            fwft_r <= fwft_sel;
        end else if (fetch) begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    // Output register and its occupancy bit (the bit is used only in look-ahead style).
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            valid   <= 1'b0;
        end else begin
            if (fetch)        rd_data <= rd_word;
            if (!fwft_r)      valid   <= 1'b0;
            else if (fetch)   valid   <= 1'b1;
            else if (pop)     valid   <= 1'b0;
        end
    end

    // Registered low-level flag for synchronous timing.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) ae_q <= 1'b0;
        else        ae_q <= (total > ae_lim);
    end

    // Read-edge moves of the asynchronous flags: raise "almost empty", drop "almost full".
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            ae_set <= 1'b0;
            af_clr <= 1'b0;
        end else begin
            if (pop && (tot_after <= ae_lim) && (ae_set != ae_clr_sync))
                ae_set <= ~ae_set;
            if (pop && (tot_after < af_lim) && (af_clr != af_set_sync))
                af_clr <= ~af_clr;
        end
    end

    // R4: a normal-style read request with nothing stored changes neither pointer nor data.
    a_r4_no_read_when_empty: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!fwft_r && ram_empty && !rd_en_n) |=> ((rbin == $past(rbin)) && $stable(rd_data)));

    // R5: in look-ahead style an empty output stage is refilled on the next edge.
    a_r5_fwft_autoload: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (fwft_r && !valid && !ram_empty) |=> valid);

    // R2: the Gray pointer moves at most one bit per edge.
    a_r2_rgray_one_step: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(rgray ^ $past(rgray)) <= 1));

    // R12: both captured modes are stable outside reset.
    a_r12_mode_held_r: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(sync_r) && $stable(fwft_r)));
endmodule

// File: rtl/dcfifo_pflag.sv
`timescale 1ns/1ps
// Dual-clock FIFO with active-low almost-empty and almost-full flags.
// It holds the storage array and ties the two clock halves together
// through Gray-pointer and toggle synchronizers. The asynchronous flag
// outputs are the XOR of a write-side toggle and a read-side toggle, so
// each flag moves right after the edge of whichever clock changes it.
// Assumes rst_n is held low across at least two edges of each clock.
module dcfifo_pflag #(
    parameter int DW     = 8,
    parameter int AW     = 4,
    parameter int AE_OFS = 3,
    parameter int AF_OFS = 2
) (
    input  logic          wr_clk,
    input  logic          wr_en_n,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_clk,
    input  logic          rd_en_n,
    output logic [DW-1:0] rd_data,
    input  logic          rst_n,
    input  logic          sync_sel,
    input  logic          fwft_sel,
    output logic          ae_n,
    output logic          af_n
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic          wr_fire;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [PW-1:0] wgray;
    logic [PW-1:0] rgray;
    logic [PW-1:0] wbin_sync;
    logic [PW-1:0] rbin_sync;
    logic [DW-1:0] rd_word;
    logic          af_set, af_clr, ae_set, ae_clr;
    logic          af_set_sync, af_clr_sync, ae_set_sync, ae_clr_sync;
    logic          af_q, ae_q, sync_w, sync_r;

    // Storage array: written on wr_clk, read without a clock by the read half.
    always_ff @(posedge wr_clk) begin
        if (wr_fire) mem[waddr] <= wr_data;
    end
    assign rd_word = mem[raddr];

    dcf_wr_side #(.AW(AW), .AE_OFS(AE_OFS), .AF_OFS(AF_OFS), .PW(PW)) u_wr (
        .wr_clk(wr_clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .sync_sel(sync_sel),
        .rbin_sync(rbin_sync), .af_clr_sync(af_clr_sync), .ae_set_sync(ae_set_sync),
        .wr_fire(wr_fire), .waddr(waddr), .wgray(wgray), .af_set(af_set),
        .ae_clr(ae_clr), .af_q(af_q), .sync_w(sync_w)
    );

    dcf_rd_side #(.DW(DW), .AW(AW), .AE_OFS(AE_OFS), .AF_OFS(AF_OFS), .PW(PW)) u_rd (
        .rd_clk(rd_clk), .rst_n(rst_n), .rd_en_n(rd_en_n), .sync_sel(sync_sel),
        .fwft_sel(fwft_sel), .wbin_sync(wbin_sync), .rd_word(rd_word),
        .af_set_sync(af_set_sync), .ae_clr_sync(ae_clr_sync), .raddr(raddr),
        .rgray(rgray), .rd_data(rd_data), .ae_set(ae_set), .af_clr(af_clr),
        .ae_q(ae_q), .sync_r(sync_r)
    );

    // Pointer crossings in both directions.
    dcf_xing #(.W(PW)) u_w2r_ptr (.clk(rd_clk), .rst_n(rst_n), .gray_in(wgray), .bin_out(wbin_sync));
    dcf_xing #(.W(PW)) u_r2w_ptr (.clk(wr_clk), .rst_n(rst_n), .gray_in(rgray), .bin_out(rbin_sync));

    // Toggle crossings so each side knows the flag state the other side left.
    dcf_xing #(.W(1)) u_afset_x (.clk(rd_clk), .rst_n(rst_n), .gray_in(af_set), .bin_out(af_set_sync));
    dcf_xing #(.W(1)) u_aeclr_x (.clk(rd_clk), .rst_n(rst_n), .gray_in(ae_clr), .bin_out(ae_clr_sync));
    dcf_xing #(.W(1)) u_afclr_x (.clk(wr_clk), .rst_n(rst_n), .gray_in(af_clr), .bin_out(af_clr_sync));
    dcf_xing #(.W(1)) u_aeset_x (.clk(wr_clk), .rst_n(rst_n), .gray_in(ae_set), .bin_out(ae_set_sync));

    // Flag output selection by the captured timing mode of each flag's home domain.
    always_comb begin
        af_n = sync_w ? af_q : ~(af_set ^ af_clr);
        ae_n = sync_r ? ae_q : (ae_set ^ ae_clr);
    end

    // R1: directly after reset the low-level flag is asserted.
    a_r1_ae_after_reset: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !$past(rst_n) |-> !ae_n);

    // R1: directly after reset the high-level flag is deasserted.
    a_r1_af_after_reset: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !$past(rst_n) |-> af_n);
endmodule

// File: tb/sim_dcfifo_pflag.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module sim_dcfifo_pflag;
    localparam int DW = 8, AW = 4, AE_OFS = 3, AF_OFS = 2;

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          wr_en_n = 1'b1, rd_en_n = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          rst_n = 1'b0, sync_sel = 1'b0, fwft_sel = 1'b0;
    logic          ae_n, af_n;
    int            n_chk = 0, n_fail = 0;

    always #10 wr_clk = ~wr_clk;
    always #15 rd_clk = ~rd_clk;

    dcfifo_pflag #(.DW(DW), .AW(AW), .AE_OFS(AE_OFS), .AF_OFS(AF_OFS)) u0 (
        .wr_clk(wr_clk), .wr_en_n(wr_en_n), .wr_data(wr_data), .rd_clk(rd_clk),
        .rd_en_n(rd_en_n), .rd_data(rd_data), .rst_n(rst_n), .sync_sel(sync_sel),
        .fwft_sel(fwft_sel), .ae_n(ae_n), .af_n(af_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic s, input logic f);
        wr_en_n = 1'b1; rd_en_n = 1'b1;
        rst_n = 1'b0; sync_sel = s; fwft_sel = f;
        repeat (6) @(negedge wr_clk);
        rst_n = 1'b1;
        repeat (4) @(negedge rd_clk);
    endtask

    task automatic wr1(input logic [DW-1:0] d);
        @(negedge wr_clk); wr_en_n = 1'b0; wr_data = d;
        @(negedge wr_clk); wr_en_n = 1'b1;
    endtask

    task automatic rd1();
        @(negedge rd_clk); rd_en_n = 1'b0;
        @(negedge rd_clk); rd_en_n = 1'b1;
    endtask

    task automatic settle();
        repeat (6) @(negedge wr_clk);
        repeat (6) @(negedge rd_clk);
    endtask

    // R1: flag levels after reset in both timing modes.
    task automatic t_reset();
        do_reset(1'b0, 1'b0);
        chk("R1 ae_n async", ae_n, 0);
        chk("R1 af_n async", af_n, 1);
        do_reset(1'b1, 1'b0);
        chk("R1 ae_n sync", ae_n, 0);
        chk("R1 af_n sync", af_n, 1);
    endtask

    // R2, R3, R4: ordering, full drop, empty read.
    task automatic t_order_full();
        do_reset(1'b1, 1'b0);
        for (int i = 0; i < 17; i++) wr1(DW'(8'h40 + i));
        settle();
        chk("R3 af_n when full", af_n, 0);
        for (int i = 0; i < 16; i++) begin
            rd1();
            chk("R2 order / R3 depth", rd_data, 32'h40 + i);
        end
        rd1();
        chk("R4 read while empty holds data", rd_data, 32'h4F);
        settle();
        chk("R4 ae_n after drain", ae_n, 0);
    endtask

    // R5, R7, R8, R12: look-ahead style thresholds and depth.
    task automatic t_fwft();
        do_reset(1'b1, 1'b1);
        fwft_sel = 1'b0;
        chk("R1 ae_n fwft", ae_n, 0);
        wr1(8'h80); settle();
        chk("R5 first word without read", rd_data, 32'h80);
        chk("R12 fwft kept after pin change", rd_data, 32'h80);
        for (int i = 1; i < 4; i++) begin wr1(DW'(8'h80 + i)); settle(); end
        chk("R7 ae_n at n+1 words", ae_n, 0);
        wr1(8'h84); settle();
        chk("R7 ae_n above n+1", ae_n, 1);
        for (int i = 5; i < 14; i++) begin wr1(DW'(8'h80 + i)); settle(); end
        chk("R8 af_n at D-m-1 (fwft)", af_n, 1);
        wr1(8'h8E); settle();
        chk("R8 af_n at D-m (fwft)", af_n, 0);
        for (int i = 15; i < 18; i++) wr1(DW'(8'h80 + i));
        settle();
        for (int i = 0; i < 17; i++) begin
            chk("R5 fwft order and depth", rd_data, 32'h80 + i);
            rd1();
        end
        settle();
        chk("R5 ae_n after drain", ae_n, 0);
    endtask

    // R6, R8, R10: synchronous timing in normal style.
    task automatic t_sync_std();
        do_reset(1'b1, 1'b0);
        for (int i = 0; i < 3; i++) begin wr1(DW'(i)); settle(); end
        chk("R6 ae_n at n", ae_n, 0);
        wr1(8'h03); settle();
        chk("R6 ae_n at n+1", ae_n, 1);
        rd1(); settle();
        chk("R6 ae_n back at n", ae_n, 0);
        for (int i = 0; i < 10; i++) begin wr1(DW'(i)); settle(); end
        chk("R8 af_n at D-m-1", af_n, 1);
        wr1(8'hEE);
        chk("R10 af_n still high half cycle after", af_n, 1);
        @(negedge wr_clk);
        chk("R10 af_n low one cycle later", af_n, 0);
        settle();
        rd1(); settle();
        chk("R8 af_n below D-m", af_n, 1);
    endtask

    // R9, R11, R12: asynchronous timing, edge-immediate flag moves.
    task automatic t_async();
        do_reset(1'b0, 1'b0);
        sync_sel = 1'b1;
        for (int i = 0; i < 3; i++) begin wr1(DW'(i)); settle(); end
        chk("R11 ae_n at n", ae_n, 0);
        wr1(8'h03);
        chk("R11 ae_n high right after write edge", ae_n, 1);
        settle();
        rd1();
        chk("R11 ae_n low right after read edge", ae_n, 0);
        settle();
        for (int i = 0; i < 10; i++) begin wr1(DW'(i)); settle(); end
        chk("R9 af_n at D-m-1", af_n, 1);
        wr1(8'hAA);
        chk("R9 R12 af_n low right after write edge", af_n, 0);
        settle();
        rd1();
        chk("R9 af_n high right after read edge", af_n, 1);
    endtask

    initial begin
        t_reset();
        t_order_full();
        t_fwft();
        t_sync_std();
        t_async();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule